// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block holds the gain code for the left and right channels of a stereo audio path and decides when a newly written code takes effect. A write carries a target code and a zero-crossing enable. With the enable clear, both channels take the new code on the next clock. With the enable set, each channel waits for its own zero crossing and commits on it. A channel with no crossing commits when a shared timeout expires. The timeout is counted in sample strobes.

Each channel keeps its own applied code. A later write restarts the timeout and retargets both channels. A channel that already committed the earlier code keeps that code until the new one is applied, so the two channels can differ for a while. A calibration hold input forces both channels to mute (code 0). Mapping codes to decibels is left to the analog side.

Top module: `zc_gain_ctrl`

## Requirements
- R1: After reset both applied gains are 0 (mute) and the completion flag `done` is 1.
- R2: A write with `wr_zc_en`=0 sets both applied gains to `wr_gain` on the clock edge of the write, and `done` is 1 after it.
- R3: After a write with `wr_zc_en`=1, a channel commits the target on the edge of a strobed sample whose sign bit (MSB, two's complement) differs from that channel's previous strobed sample. The other channel is not affected by this crossing.
- R4: A strobed sample exactly equal to zero counts as a crossing for its channel, even with no earlier sample.
- R5: The timeout selector `tmo_sel` picks 256 (00), 512 (01), 1024 (10) or 2048 (11) sample strobes. The count starts at the zero-crossing write. A channel still pending commits the target on the strobe that completes the count.
- R6: A zero-crossing write while a change is pending restarts the timeout and makes the new value the target of both channels. A channel that committed the earlier value keeps it until the new target is applied.
- R7: A zero-crossing write of a value equal to a channel's applied gain finishes at once for that channel. If it equals both channels' gains, `done` stays 1.
- R8: `done` is 0 in the cycle after a zero-crossing write that leaves a channel pending. It returns to 1 on the edge where the last pending channel commits.
- R9: While `cal_hold` is 1, both gains are forced to 0, pending changes are dropped, writes are ignored and `done` is 1.
- R10: A sample present while `smp_stb` is 0 neither counts as a crossing nor advances the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_hold | input | 1 | Calibration hold: forces mute and blocks writes |
| smp_stb | input | 1 | One-cycle strobe marking a valid sample pair |
| smp_l | input | SMP_W | Left sample, two's complement |
| smp_r | input | SMP_W | Right sample, two's complement |
| wr_stb | input | 1 | Gain write strobe |
| wr_zc_en | input | 1 | 1: commit at zero crossing or timeout; 0: commit at once |
| wr_gain | input | GAIN_W | Target gain code (0 = mute) |
| tmo_sel | input | 2 | Timeout selector |
| gain_l | output | GAIN_W | Applied left gain |
| gain_r | output | GAIN_W | Applied right gain |
| done | output | 1 | Both channels hold the current target |

## Verification
The hardest case to reach from the ports is a retarget while the channels are split. In this case one channel has committed, the other is still waiting, and the timeout has already run part of its count. The directed stimulus gets there in three steps. It sends a crossing on one channel only and holds the other channel's sign fixed for about a hundred strobes. It then writes a new target. After that it counts strobes up to the exact restarted limit, checking one strobe before the expiry and on the expiry strobe. Random traffic with a fixed seed then mixes writes, crossings, exact-zero samples and calibration holds, and a bench model checks every cycle.

// File: rtl/zcg_pkg.sv
package zcg_pkg;

    typedef enum logic [1:0] {
        TMO_X1 = 2'b00,
        TMO_X2 = 2'b01,
        TMO_X4 = 2'b10,
        TMO_X8 = 2'b11
    } tmo_sel_e;

    // Last count value before expiry: base scaled by 1, 2, 4 or 8.
    function automatic int tmo_last(input int base, input logic [1:0] sel);
        return (base << sel) - 1;
    endfunction

endpackage

// File: rtl/zcg_zc_detect.sv
module zcg_zc_detect #(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [SMP_W-1:0] smp,
    output logic             zc
);

    typedef struct packed {
        logic sign;
        logic seen;
    } hist_t;

    hist_t h_q, h_d;

    always_comb begin
        h_d = h_q;
        zc  = 1'b0;
        if (stb) begin
            zc = (smp == '0) || (h_q.seen && (smp[SMP_W-1] != h_q.sign));
            h_d.sign = smp[SMP_W-1];
            h_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    // R10: history moves only on a strobe
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(h_q));

endmodule

// File: rtl/zcg_timeout.sv
module zcg_timeout #(
    parameter int TMO_BASE = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       active,
    input  logic       stb,
    input  logic [1:0] sel,
    output logic       expire
);
    import zcg_pkg::*;

    localparam int TMO_W = $clog2(TMO_BASE) + 3;

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } tmo_t;

    tmo_t t_q, t_d;
    logic [TMO_W-1:0] last;

    always_comb begin
        last   = TMO_W'(tmo_last(TMO_BASE, sel));
        expire = active && stb && !restart && (t_q.cnt >= last);
        t_d    = t_q;
        if (restart || !active || expire) t_d.cnt = '0;
        else if (stb)                     t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R5: a restart always brings the count back to zero
    a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (t_q.cnt == '0));

endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl #(
    parameter int GAIN_W   = 7,
    parameter int SMP_W    = 16,
    parameter int TMO_BASE = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_hold,
    input  logic              smp_stb,
    input  logic [SMP_W-1:0]  smp_l,
    input  logic [SMP_W-1:0]  smp_r,
    input  logic              wr_stb,
    input  logic              wr_zc_en,
    input  logic [GAIN_W-1:0] wr_gain,
    input  logic [1:0]        tmo_sel,
    output logic [GAIN_W-1:0] gain_l,
    output logic [GAIN_W-1:0] gain_r,
    output logic              done
);

    localparam int CH = 2;

    typedef struct packed {
        logic [CH-1:0][GAIN_W-1:0] gain;
        logic [CH-1:0]             pend;
        logic [GAIN_W-1:0]         tgt;
        logic                      done;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [SMP_W-1:0] smp [CH];
    logic [CH-1:0]    zc;
    logic             tmo_exp;
    logic             tmo_restart;
    logic             tmo_active;

    assign smp[0] = smp_l;
    assign smp[1] = smp_r;

    for (genvar ch = 0; ch < CH; ch++) begin : g_det
        zcg_zc_detect #(.SMP_W(SMP_W)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (smp_stb),
            .smp   (smp[ch]),
            .zc    (zc[ch])
        );
    end

    assign tmo_restart = wr_stb && wr_zc_en && !cal_hold;
    assign tmo_active  = |c_q.pend;

    zcg_timeout #(.TMO_BASE(TMO_BASE)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmo_restart),
        .active  (tmo_active),
        .stb     (smp_stb),
        .sel     (tmo_sel),
        .expire  (tmo_exp)
    );

    always_comb begin
        c_d = c_q;
        if (cal_hold) begin
            c_d.gain = '0;
            c_d.pend = '0;
            c_d.tgt  = '0;
        end else if (wr_stb) begin
            c_d.tgt = wr_gain;
            for (int ch = 0; ch < CH; ch++) begin
                if (wr_zc_en) begin
                    c_d.pend[ch] = (c_q.gain[ch] != wr_gain);
                end else begin
                    c_d.gain[ch] = wr_gain;
                    c_d.pend[ch] = 1'b0;
                end
            end
        end else begin
            for (int ch = 0; ch < CH; ch++) begin
                if (c_q.pend[ch] && (zc[ch] || tmo_exp)) begin
                    c_d.gain[ch] = c_q.tgt;
                    c_d.pend[ch] = 1'b0;
                end
            end
        end
        c_d.done = ~|c_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.done <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign gain_l = c_q.gain[0];
    assign gain_r = c_q.gain[1];
    assign done   = c_q.done;

    // R2: an immediate write lands on both channels
    a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_zc_en && !cal_hold) |=>
            (gain_l == $past(wr_gain)) && (gain_r == $past(wr_gain)) && done);

    // R9: calibration hold mutes both channels
    a_r9_cal_mute: assert property (@(posedge clk) disable iff (!rst_n)
        cal_hold |=> (gain_l == '0) && (gain_r == '0) && done);

    // R5: an expiry leaves no channel pending
    a_r5_expire_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_exp && !wr_stb && !cal_hold) |=> (c_q.pend == '0));

    // R6: a committed channel holds its gain until a write arrives
    a_r6_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb && !cal_hold && !c_q.pend[0]) |=> $stable(gain_l));

    // R8: completion means both channels carry the target
    a_r8_done_target: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (gain_l == c_q.tgt) && (gain_r == c_q.tgt));

endmodule

// File: tb/zc_gain_ctrl_bench.sv
module zc_gain_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_hold = 1'b0;
    logic        smp_stb = 1'b0;
    logic [15:0] smp_l = '0;
    logic [15:0] smp_r = '0;
    logic        wr_stb = 1'b0;
    logic        wr_zc_en = 1'b0;
    logic [6:0]  wr_gain = '0;
    logic [1:0]  tmo_sel = 2'b00;
    logic [6:0]  gain_l, gain_r;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    // model state
    logic [6:0] m_gl = 0, m_gr = 0, m_tgt = 0;
    logic       m_pl = 0, m_pr = 0;
    int         m_cnt = 0;
    logic       m_sl = 0, m_sr = 0, m_vl = 0, m_vr = 0;

    always #4 clk = ~clk;

    zc_gain_ctrl u_zc_gain_ctrl (
        .clk(clk), .rst_n(rst_n), .cal_hold(cal_hold), .smp_stb(smp_stb),
        .smp_l(smp_l), .smp_r(smp_r), .wr_stb(wr_stb), .wr_zc_en(wr_zc_en),
        .wr_gain(wr_gain), .tmo_sel(tmo_sel),
        .gain_l(gain_l), .gain_r(gain_r), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit crossing(input logic [15:0] s, input logic v, input logic prev);
        return (s == 16'd0) || (v && (s[15] != prev));
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // One clock: drive inputs, advance model, compare after the edge.
    task automatic step(input logic wr, input logic zen, input logic [6:0] g,
                        input logic stb, input logic [15:0] l, input logic [15:0] r,
                        input string tag);
        bit zl, zr, ex;
        int lim;
        wr_stb = wr; wr_zc_en = zen; wr_gain = g;
        smp_stb = stb; smp_l = l; smp_r = r;
        zl  = stb && crossing(l, m_vl, m_sl);
        zr  = stb && crossing(r, m_vr, m_sr);
        lim = 256 << tmo_sel;
        if (cal_hold) begin
            m_gl = 0; m_gr = 0; m_pl = 0; m_pr = 0; m_tgt = 0; m_cnt = 0;
        end else if (wr) begin
            m_tgt = g; m_cnt = 0;
            if (!zen) begin
                m_gl = g; m_gr = g; m_pl = 0; m_pr = 0;
            end else begin
                m_pl = (m_gl != g); m_pr = (m_gr != g);
            end
        end else if (m_pl || m_pr) begin
            ex = stb && (m_cnt >= lim - 1);
            if (m_pl && (zl || ex)) begin m_gl = m_tgt; m_pl = 0; end
            if (m_pr && (zr || ex)) begin m_gr = m_tgt; m_pr = 0; end
            if (ex) m_cnt = 0;
            else if (stb) m_cnt++;
        end else begin
            m_cnt = 0;
        end
        if (stb) begin
            m_sl = l[15]; m_vl = 1; m_sr = r[15]; m_vr = 1;
        end
        @(posedge clk); #1;
        chk({tag, " gain_l"}, gain_l, m_gl);
        chk({tag, " gain_r"}, gain_r, m_gr);
        chk({tag, " done"}, done, !(m_pl || m_pr));
        wr_stb = 0; smp_stb = 0;
    endtask

    task automatic strobes(input int n, input logic [15:0] l, input logic [15:0] r,
                           input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 1, l, r, tag);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1 gain_l", gain_l, 0);
        chk("R1 gain_r", gain_r, 0);
        chk("R1 done", done, 1);

        // R2: immediate write
        step(1, 0, 7'h28, 0, 0, 0, "R2");
        chk("R2 gain_l", gain_l, 7'h28);
        chk("R2 gain_r", gain_r, 7'h28);

        strobes(1, 16'd100, 16'd100, "R3");
        step(1, 1, 7'h30, 0, 0, 0, "R8");
        chk("R8 done low", done, 0);
        chk("R8 gain_l unchanged", gain_l, 7'h28);
        // R3: left crosses only
        step(0, 0, 0, 1, -16'sd5, 16'd7, "R3");
        chk("R3 gain_l", gain_l, 7'h30);
        chk("R3 gain_r", gain_r, 7'h28);
        // R4: exact zero on right
        step(0, 0, 0, 1, -16'sd3, 16'd0, "R4");
        chk("R4 gain_r", gain_r, 7'h30);
        chk("R8 done high", done, 1);

        // R10 and R5 with selector 01 (512)
        strobes(1, 16'd2, 16'd2, "R5");
        tmo_sel = 2'b01;
        step(1, 1, 7'h31, 0, 0, 0, "R5");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, -16'sd9, -16'sd9, "R10");
        chk("R10 gain_l", gain_l, 7'h30);
        chk("R10 gain_r", gain_r, 7'h30);
        strobes(511, 16'd2, 16'd2, "R5");
        chk("R5 before expiry", gain_l, 7'h30);
        strobes(1, 16'd2, 16'd2, "R5");
        chk("R5 gain_l", gain_l, 7'h31);
        chk("R5 gain_r", gain_r, 7'h31);

        // R6: retarget after a split
        tmo_sel = 2'b00;
        step(1, 1, 7'h40, 0, 0, 0, "R6");
        strobes(100, -16'sd1, 16'd1, "R6");
        chk("R6 left committed", gain_l, 7'h40);
        step(1, 1, 7'h41, 0, 0, 0, "R6");
        chk("R6 gain_l kept", gain_l, 7'h40);
        chk("R6 gain_r kept", gain_r, 7'h31);
        strobes(255, -16'sd1, 16'd1, "R6");
        chk("R6 before restarted expiry", gain_r, 7'h31);
        strobes(1, -16'sd1, 16'd1, "R6");
        chk("R6 gain_l", gain_l, 7'h41);
        chk("R6 gain_r", gain_r, 7'h41);

        // R7: equal values
        step(1, 1, 7'h41, 0, 0, 0, "R7");
        chk("R7 done both equal", done, 1);
        step(1, 1, 7'h42, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 16'd1, 16'd1, "R7");
        chk("R7 split gain_l", gain_l, 7'h42);
        step(1, 1, 7'h42, 0, 0, 0, "R7");
        chk("R7 left equal stays", gain_l, 7'h42);
        chk("R7 right pending", done, 0);
        step(0, 0, 0, 1, 16'd1, 16'd0, "R7");
        chk("R7 gain_r", gain_r, 7'h42);
        chk("R7 done", done, 1);

        // R9: calibration hold
        cal_hold = 1;
        step(1, 0, 7'h55, 0, 0, 0, "R9");
        chk("R9 gain_l", gain_l, 0);
        chk("R9 gain_r", gain_r, 0);
        step(1, 1, 7'h56, 1, 0, 0, "R9");
        chk("R9 done", done, 1);
        cal_hold = 0;

        // random mix checked against the model
        for (int i = 0; i < 6000; i++) begin
            logic [15:0] l, r;
            logic wr, zen, stb;
            l = m_sl ? -16'sd20 : 16'sd20;
            r = m_sr ? -16'sd30 : 16'sd30;
            if ($urandom_range(0, 15) == 0) l = -l;
            if ($urandom_range(0, 15) == 0) r = -r;
            if ($urandom_range(0, 40) == 0) l = 0;
            if ($urandom_range(0, 60) == 0) r = 0;
            wr  = ($urandom_range(0, 150) == 0);
            zen = ($urandom_range(0, 3) != 0);
            stb = ($urandom_range(0, 1) == 0);
            cal_hold = ($urandom_range(0, 500) == 0);
            step(wr, zen, 7'($urandom_range(0, 127)), stb, l, r, "R3 random");
        end
        cal_hold = 0;
        finish_run();
    end

endmodule